// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a register-facing side and a serial shift engine. It holds a transmit FIFO, filled by the register side and drained by the engine, and a receive FIFO, filled by the engine and drained by the register side. It reports both fill levels and a six-bit status word, and it raises one combined interrupt line.

Interrupt sources fall into two groups. Level sources follow FIFO state: transmit FIFO empty, and receive level above a programmable threshold. Sticky sources latch error events until software clears them: transmit overflow, receive underflow, receive overflow and chip-select going inactive. Software sees the raw sources and the masked sources separately. It can clear all sticky sources at once or one at a time.

When the enable input drops, both FIFOs are flushed. The receive threshold is captured only while the unit is disabled, so it cannot change during a transfer.

Top module: `spi_fifo_stat`

## Requirements
- R1: Each FIFO holds up to DEPTH words (DEPTH is 32 or 64) and delivers them in the order written. Each reports its fill level from 0 to DEPTH. The level moves one cycle after an accepted push or pop and stays the same when both happen together. The head word is visible on the read data port whenever the FIFO is not empty.
- R2: `status` bits are: [0] engine busy input, [1] TX FIFO full, [2] TX FIFO empty, [3] RX FIFO empty, [4] RX FIFO full, [5] slave transmit busy input.
- R3: A TX push while the TX FIFO holds DEPTH words is dropped. The cycle after, it sets raw bit 1 (TX overflow), which stays set until cleared.
- R4: An RX pop from an empty RX FIFO returns zero on `rx_rdata`. The cycle after, it sets raw bit 2 (RX underflow). An RX push into a full RX FIFO is dropped and sets raw bit 3 (RX overflow). Both bits are sticky.
- R5: Raw bit 0 is 1 exactly when the TX FIFO is empty. Raw bit 4 is 1 exactly when the RX level is strictly greater than the captured threshold. Raw bit 5 is always 0.
- R6: The threshold is loaded from `rx_thresh` on every cycle that `enable` is low. Changes to `rx_thresh` while `enable` is high have no effect.
- R7: A `clr_wr` strobe with `clr_bits` bit 0 clears raw bits 1, 2, 3 and 6. Bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. Raw bit 6 is set the cycle after a `cs_inactive` pulse and is sticky.
- R8: If a clear and a new event for the same sticky source happen in the same cycle, the source is set after that cycle.
- R9: `irq_masked` equals `irq_raw` AND `irq_mask`. `irq` is the OR of `irq_masked`.
- R10: While `enable` is low, both levels go to zero after one clock. Pushes and pops are ignored, and no overflow or underflow event is raised.
- R11: After reset, both levels, all sticky sources and the threshold are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Unit enable; low flushes FIFOs and loads threshold |
| tx_push | input | 1 | Register side writes a TX word |
| tx_wdata | input | DW | TX write data |
| tx_pop | input | 1 | Engine takes a TX word |
| tx_rdata | output | DW | TX head word (0 when empty) |
| rx_push | input | 1 | Engine writes an RX word |
| rx_wdata | input | DW | RX write data |
| rx_pop | input | 1 | Register side reads an RX word |
| rx_rdata | output | DW | RX head word (0 when empty) |
| rx_thresh | input | LW | RX threshold value |
| irq_mask | input | 7 | Interrupt mask |
| clr_wr | input | 1 | Clear write strobe |
| clr_bits | input | 4 | Clear write data |
| engine_busy | input | 1 | Serial engine busy |
| slave_tx_busy | input | 1 | Slave transmit busy |
| cs_inactive | input | 1 | Chip-select went inactive event |
| tx_level | output | LW | TX fill level |
| rx_level | output | LW | RX fill level |
| status | output | 6 | Status word |
| irq_raw | output | 7 | Raw interrupt sources |
| irq_masked | output | 7 | Masked interrupt sources |
| irq | output | 1 | Combined interrupt |

## Verification
The tests first fill the TX FIFO past DEPTH. This separates a correct full boundary from an off-by-one that accepts one extra word. A drain past empty on the RX side checks the zero read data and the underflow flag. The RX level is then swept across the threshold, which separates strict from non-strict comparison. The threshold is also changed while enabled to show it is held.

Clears are issued alone, selectively, and in the same cycle as a fresh event, which exposes wrong clear decoding and wrong priority. A long stretch of random pushes, pops, masks and clears then runs against a queue-based model. The unit is disabled mid-traffic to check the flush and that events are suppressed.

// File: rtl/sfs_pkg.sv
// Package: shared bit positions for the FIFO status and interrupt unit.
// Assumes nothing beyond being compiled first.
package sfs_pkg;
    localparam int IRQ_W    = 7;
    localparam int ST_W     = 6;
    localparam int CLR_W    = 4;
    // raw interrupt bit positions
    localparam int IRQ_TXE  = 0;
    localparam int IRQ_TXOV = 1;
    localparam int IRQ_RXUN = 2;
    localparam int IRQ_RXOV = 3;
    localparam int IRQ_RXTH = 4;
    localparam int IRQ_CSI  = 6;
    // number of sticky sources handled by the interrupt block
    localparam int N_STICKY = 4;
endpackage

// File: rtl/sfs_fifo.sv
// Module: synchronous FIFO with first-word fall-through read data.
// Assumes DEPTH is a power of two; a push into a full FIFO is dropped,
// a pop from an empty FIFO is ignored and the read data reads zero.
module sfs_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign level   = cnt;
    assign rdata   = empty ? '0 : mem[rp];

    // storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // pointer and count update, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/sfs_irq.sv
// Module: raw/masked interrupt collection with sticky error sources.
// Assumes events are single-cycle strobes; an event beats a clear in
// the same cycle.
module sfs_irq
    import sfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STICKY-1:0] ev,       // {csi, rxov, rxun, txov}
    input  logic             tx_empty,
    input  logic             rx_hit,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_bits,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic [N_STICKY-1:0] sticky, clr_vec;

    // which sticky sources a clear write touches
    always_comb begin
        clr_vec    = '0;
        clr_vec[0] = clr_wr && (clr_bits[0] || clr_bits[3]);
        clr_vec[1] = clr_wr && (clr_bits[0] || clr_bits[1]);
        clr_vec[2] = clr_wr && (clr_bits[0] || clr_bits[2]);
        clr_vec[3] = clr_wr && clr_bits[0];
    end

    // one sticky flop per error source
    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) sticky[i] <= 1'b0;
            else        sticky[i] <= (sticky[i] && !clr_vec[i]) || ev[i];
        end
    end

    // assemble raw source vector
    always_comb begin
        raw           = '0;
        raw[IRQ_TXE]  = tx_empty;
        raw[IRQ_TXOV] = sticky[0];
        raw[IRQ_RXUN] = sticky[1];
        raw[IRQ_RXOV] = sticky[2];
        raw[IRQ_RXTH] = rx_hit;
        raw[IRQ_CSI]  = sticky[3];
    end

    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_stat.sv
// Module: top of the FIFO status and interrupt unit. Two FIFOs, the
// threshold register, status word and interrupt block.
// Assumes DEPTH of 32 or 64; threshold is sampled only while disabled.
module spi_fifo_stat
    import sfs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_wdata,
    input  logic             tx_pop,
    output logic [DW-1:0]    tx_rdata,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_wdata,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_rdata,
    input  logic [LW-1:0]    rx_thresh,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_bits,
    input  logic             engine_busy,
    input  logic             slave_tx_busy,
    input  logic             cs_inactive,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic [ST_W-1:0]  status,
    output logic [IRQ_W-1:0] irq_raw,
    output logic [IRQ_W-1:0] irq_masked,
    output logic             irq
);
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [LW-1:0] thr_q;
    logic [N_STICKY-1:0] ev;

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(!enable),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(!enable),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // threshold register, loaded only while the unit is disabled
    always_ff @(posedge clk) begin
        if (!rst_n)       thr_q <= '0;
        else if (!enable) thr_q <= rx_thresh;
    end

    // error event strobes, suppressed while disabled except chip-select
    always_comb begin
        ev[0] = enable && tx_push && tx_full;
        ev[1] = enable && rx_pop && rx_empty;
        ev[2] = enable && rx_push && rx_full;
        ev[3] = cs_inactive;
    end

    // status word
    assign status = {slave_tx_busy, rx_full, rx_empty, tx_empty, tx_full, engine_busy};

    sfs_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .tx_empty(tx_empty), .rx_hit(rx_level > thr_q),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .mask(irq_mask),
        .raw(irq_raw), .masked(irq_masked), .irq(irq)
    );
endmodule

// File: rtl/sfs_chk.sv
// Module: property checker for spi_fifo_stat, attached by bind.
// Assumes it observes only top-level ports.
module sfs_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          rx_pop,
    input logic          clr_wr,
    input logic [3:0]    clr_bits,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [6:0]    irq_raw,
    input logic [6:0]    irq_mask,
    input logic          irq
);
    // R1: level never exceeds depth
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

    // R3: push into full TX is dropped and flags overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tx_push && !tx_pop && tx_level == LW'(DEPTH))
        |=> (tx_level == LW'(DEPTH) && irq_raw[1]));

    // R3: overflow stays set without a matching clear
    p_txov_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[1] && !(clr_wr && (clr_bits[0] || clr_bits[3]))) |=> irq_raw[1]);

    // R4: pop from empty RX flags underflow
    p_rx_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rx_pop && rx_level == '0) |=> irq_raw[2]);

    // R7: selective clear of TX overflow when no new event
    p_txov_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[3] && !(enable && tx_push && tx_level == LW'(DEPTH)))
        |=> !irq_raw[1]);

    // R10: disabling flushes both FIFOs
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tx_level == '0 && rx_level == '0));

    // R9: no interrupt when everything is masked
    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
endmodule

bind spi_fifo_stat sfs_chk #(.DEPTH(DEPTH), .LW(LW)) u_sfs_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_push(tx_push),
    .tx_pop(tx_pop), .rx_pop(rx_pop), .clr_wr(clr_wr), .clr_bits(clr_bits),
    .tx_level(tx_level), .rx_level(rx_level), .irq_raw(irq_raw),
    .irq_mask(irq_mask), .irq(irq)
);

// File: tb/spi_fifo_stat_test.sv
// Bench: queue-based reference model compared every cycle.
module spi_fifo_stat_test;
    localparam int DW = 8;
    localparam int DEPTH = 32;
    localparam int LW = $clog2(DEPTH) + 1;

    logic clk = 0, rst_n = 0;
    logic enable = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [DW-1:0] tx_wdata = 0, rx_wdata = 0;
    logic [LW-1:0] rx_thresh = 0;
    logic [6:0] irq_mask = 0;
    logic clr_wr = 0;
    logic [3:0] clr_bits = 0;
    logic engine_busy = 0, slave_tx_busy = 0, cs_inactive = 0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic [LW-1:0] tx_level, rx_level;
    logic [5:0] status;
    logic [6:0] irq_raw, irq_masked;
    logic irq;

    int checks = 0, failures = 0;
    bit done = 0;

    // model state
    logic [DW-1:0] txq[$], rxq[$];
    bit m_tov, m_ruf, m_rov, m_csi;
    int m_thr;

    always #4 clk = ~clk;

    spi_fifo_stat #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [6:0] er;
        er = '0;
        er[0] = (txq.size() == 0);
        er[1] = m_tov; er[2] = m_ruf; er[3] = m_rov;
        er[4] = (rxq.size() > m_thr);
        er[6] = m_csi;
        chk("R1 tx_level", int'(tx_level), txq.size());
        chk("R1 rx_level", int'(rx_level), rxq.size());
        chk("R1 tx_rdata", int'(tx_rdata), txq.size() ? int'(txq[0]) : 0);
        chk("R4 rx_rdata", int'(rx_rdata), rxq.size() ? int'(rxq[0]) : 0);
        chk("R2 status", int'(status), int'({slave_tx_busy, rxq.size() == DEPTH,
            rxq.size() == 0, txq.size() == 0, txq.size() == DEPTH, engine_busy}));
        chk("R3 raw txov", int'(irq_raw[1]), int'(er[1]));
        chk("R4 raw rx err", int'(irq_raw[3:2]), int'(er[3:2]));
        chk("R5 raw level", int'({irq_raw[5:4], irq_raw[0]}), int'({er[5:4], er[0]}));
        chk("R7 raw csi", int'(irq_raw[6]), int'(er[6]));
        chk("R9 masked", int'(irq_masked), int'(er & irq_mask));
        chk("R9 irq", int'(irq), int'(|(er & irq_mask)));
    endtask

    task automatic model_next();
        bit txf, rxf, rxe;
        txf = (txq.size() == DEPTH);
        rxf = (rxq.size() == DEPTH);
        rxe = (rxq.size() == 0);
        if (clr_wr) begin
            if (clr_bits[0] || clr_bits[3]) m_tov = 0;
            if (clr_bits[0] || clr_bits[1]) m_ruf = 0;
            if (clr_bits[0] || clr_bits[2]) m_rov = 0;
            if (clr_bits[0]) m_csi = 0;
        end
        if (cs_inactive) m_csi = 1;
        if (!enable) begin
            txq.delete(); rxq.delete();
            m_thr = int'(rx_thresh);
        end else begin
            if (tx_pop && txq.size() > 0) void'(txq.pop_front());
            if (tx_push && !txf) txq.push_back(tx_wdata);
            if (tx_push && txf) m_tov = 1;
            if (rx_pop && !rxe) void'(rxq.pop_front());
            if (rx_pop && rxe) m_ruf = 1;
            if (rx_push && !rxf) rxq.push_back(rx_wdata);
            if (rx_push && rxf) m_rov = 1;
        end
    endtask

    // one cycle: settle, compare, advance model, clock, back to negedge
    task automatic step();
        #1;
        compare_all();
        model_next();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        clr_wr = 0; clr_bits = 0; cs_inactive = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_tov = 0; m_ruf = 0; m_rov = 0; m_csi = 0; m_thr = 0;
        irq_mask = 7'h7f;
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk("R11 tx_level", int'(tx_level), 0);
        chk("R11 rx_level", int'(rx_level), 0);
        chk("R11 raw", int'(irq_raw), 1);
        @(negedge clk);
        rst_n = 1;
        // load threshold 3 while disabled
        rx_thresh = 3;
        step();
        enable = 1;
        step();
        // fill TX past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            tx_push = 1; tx_wdata = DW'(i + 8'h10);
            step();
        end
        idle();
        step();
        // R3 overflow visible, level held
        chk("R3 txov", int'(irq_raw[1]), 1);
        chk("R3 full level", int'(tx_level), DEPTH);
        // selective clear of rx underflow does not touch tx overflow
        clr_wr = 1; clr_bits = 4'b0010; step(); idle(); step();
        chk("R7 txov kept", int'(irq_raw[1]), 1);
        clr_wr = 1; clr_bits = 4'b1000; step(); idle(); step();
        chk("R7 txov cleared", int'(irq_raw[1]), 0);
        // engine drains some TX while pushes continue
        for (int i = 0; i < 10; i++) begin
            tx_pop = 1; tx_push = (i % 2); tx_wdata = DW'(i); step();
        end
        idle();
        // RX fill across threshold (3): bit set at level 4
        for (int i = 0; i < 5; i++) begin
            rx_push = 1; rx_wdata = DW'(8'hA0 + i); step();
        end
        idle(); step();
        chk("R5 thresh hit", int'(irq_raw[4]), 1);
        // R6: raise threshold while enabled, no effect
        rx_thresh = 20; step(); step();
        chk("R6 thresh held", int'(irq_raw[4]), 1);
        // drain RX and one extra pop
        for (int i = 0; i < 6; i++) begin
            rx_pop = 1; step();
        end
        idle(); step();
        chk("R4 underflow", int'(irq_raw[2]), 1);
        // fill RX to overflow
        for (int i = 0; i < DEPTH + 1; i++) begin
            rx_push = 1; rx_wdata = DW'(i); step();
        end
        idle(); step();
        chk("R4 rx overflow", int'(irq_raw[3]), 1);
        clr_wr = 1; clr_bits = 4'b0100; step(); idle(); step();
        chk("R7 rxov cleared", int'(irq_raw[3]), 0);
        // R8: clear and new overflow same cycle
        clr_wr = 1; clr_bits = 4'b0100; rx_push = 1; step(); idle(); step();
        chk("R8 event wins", int'(irq_raw[3]), 1);
        // chip-select event and clear-all
        cs_inactive = 1; step(); idle(); step();
        chk("R7 csi set", int'(irq_raw[6]), 1);
        clr_wr = 1; clr_bits = 4'b0001; step(); idle(); step();
        chk("R7 clear all", int'({irq_raw[6], irq_raw[3:1]}), 0);
        // masked subset
        irq_mask = 7'b0000001; step();
        irq_mask = 7'b0010000; step();
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            tx_push = ($urandom % 2) == 0;
            tx_pop = ($urandom % 5) < 2;
            rx_push = ($urandom % 5) < 2;
            rx_pop = ($urandom % 2) == 0;
            tx_wdata = DW'($urandom); rx_wdata = DW'($urandom);
            clr_wr = ($urandom % 16) == 0;
            clr_bits = 4'($urandom);
            cs_inactive = ($urandom % 64) == 0;
            engine_busy = 1'($urandom); slave_tx_busy = 1'($urandom);
            if ((i % 97) == 0) irq_mask = 7'($urandom);
            if ((i % 500) == 499) begin
                enable = 0; rx_thresh = LW'($urandom % DEPTH);
            end else begin
                enable = 1;
            end
            step();
        end
        // R10: disable with pushes pending, flush and no events
        idle();
        clr_wr = 1; clr_bits = 4'b0001; step(); idle();
        enable = 0; tx_push = 1; rx_pop = 1; rx_push = 1;
        step(); step();
        chk("R10 tx flushed", int'(tx_level), 0);
        chk("R10 rx flushed", int'(rx_level), 0);
        chk("R10 no events", int'(irq_raw[3:1]), 0);
        idle(); enable = 1; step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule